// File: doc/BRIEF.md
# Half-Bridge Break-Before-Make Sequencer

This block commands the high-side and low-side switches of a half-bridge from a single select input. On every change of the select input it first drops the command of the switch that is conducting. It then waits for a digital flag that reports that switch's gate-to-source voltage has fallen below its turn-off threshold, and only after that commands the opposite switch on. The handover therefore follows a measured gate-off event and not a fixed dead time. All analog detection (comparators, hysteresis, current sources) sits outside the block and arrives as flags. Every asynchronous input passes through a two-flop synchronizer before the state machine sees it.

Each turn-on opens a strong-drive window of 2 µs. After the window closes, the low side keeps a steady hold enable and the high side keeps a charge-pump clock of about 500 kHz. A high-side request is only latched once the switch node has been seen low, because that shows the bootstrap capacitor has been recharged. The window length and the pump divider are derived from the clock frequency parameter at elaboration. The disable input is active high, so an input tied low or left at its default tie-off leaves the bridge running. All pins are plain control levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `halfbridge_handover`

## Requirements
- R1: While reset is active and on the first cycle after it, both switch commands, both strong-drive outputs, the hold enable and the pump clock are low, and the high-side request latch is clear.
- R2: While `halt` is high (synchronized), both switch commands and all drive outputs are low within 4 cycles, and changes on `sel_top` have no effect. When `halt` returns low, the block resumes and follows `sel_top`.
- R3: With `halt` low, `sel_top` = 1 selects the high-side switch and `sel_top` = 0 selects the low-side switch.
- R4: On a selection change, the conducting switch's command drops first. The other switch is commanded on only after the outgoing switch's gate-off flag (`hi_gate_off` or `lo_gate_off`, 1 = gate below threshold) is seen. While that flag stays 0, both commands stay low.
- R5: `hi_on` and `lo_on` are never high in the same cycle.
- R6: The high-side request latch is cleared by any low level of `sel_top`. It is set only while `sel_top` is high and `sw_node_low` = 1. Without it the low side stays selected. Once it is set, `sw_node_low` returning to 0 does not drop the high side.
- R7: Each turn-on raises that side's strong-drive output (`hi_kick` / `lo_kick`) for exactly KICK_CYC cycles, starting in the first cycle of the on command. After that, `lo_hold` is high for the rest of the low-side on period.
- R8: `hi_pump` is low during the high-side strong-drive window and whenever the high side is off. After the window it toggles every PUMP_HALF cycles (period 2·PUMP_HALF).
- R9: If the selection reverses while the block waits for a gate-off flag, the switch that is turning off is not commanded on again until its gate-off flag is seen.
- R10: A change on `sel_top` does not change any switch command before the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_top | input | 1 | 1 selects the high-side switch, 0 the low-side switch |
| halt | input | 1 | Active-high disable; low or tied off means enabled |
| hi_gate_off | input | 1 | High-side gate-source voltage is below the turn-off threshold |
| lo_gate_off | input | 1 | Low-side gate-source voltage is below the turn-off threshold |
| sw_node_low | input | 1 | Switch node seen low (bootstrap capacitor charged) |
| hi_on | output | 1 | High-side switch on command |
| lo_on | output | 1 | Low-side switch on command |
| hi_kick | output | 1 | High-side strong turn-on drive window |
| lo_kick | output | 1 | Low-side strong turn-on drive window |
| lo_hold | output | 1 | Low-side steady sustain enable |
| hi_pump | output | 1 | High-side sustain charge-pump clock |

## Verification
The bench holds a gate-off flag at 0 across a handover. A design with a fixed dead time would turn the second switch on anyway, and the bench catches that. It reverses the selection in the middle of a wait. A design that jumps straight back to the outgoing switch would turn it on while its gate is still draining. It keeps the switch node high while the high side is requested, to find a latch that sets without the bootstrap condition, and it lowers the select briefly to find a latch that is never cleared. It measures the strong-drive window and the pump period in cycles, which exposes off-by-one counters and a pump that runs during the window.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;

  typedef enum logic [2:0] {
    ST_OFF        = 3'd0,
    ST_LO_ON      = 3'd1,
    ST_HI_RELEASE = 3'd2,
    ST_HI_ON      = 3'd3,
    ST_LO_RELEASE = 3'd4
  } hb_state_e;

  function automatic int unsigned ns_to_cycles(input int unsigned clk_hz,
                                               input int unsigned ns);
    longint unsigned prod;
    prod = (longint'(clk_hz) * longint'(ns)) / 64'd1_000_000_000;
    if (prod < 1) prod = 1;
    return int'(prod);
  endfunction

  function automatic int unsigned half_period(input int unsigned clk_hz,
                                              input int unsigned out_hz);
    int unsigned h;
    h = clk_hz / (2 * out_hz);
    if (h < 1) h = 1;
    return h;
  endfunction

endpackage

// File: rtl/hb_sync.sv
`timescale 1ns/1ps
module hb_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/hb_oneshot.sv
`timescale 1ns/1ps
module hb_oneshot #(
  parameter int unsigned LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  output logic kick,
  output logic hold
);

  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

  logic          on_q;
  logic [CW-1:0] left_q;
  logic          rise;

  assign rise = on & ~on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      left_q <= '0;
    end else begin
      on_q <= on;
      if (!on)
        left_q <= '0;
      else if (rise)
        left_q <= RELOAD;
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end

  assign kick = on & (rise | (left_q != '0));
  assign hold = on & ~kick;

endmodule

// File: rtl/hb_pump.sv
`timescale 1ns/1ps
module hb_pump #(
  parameter int unsigned HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pump_clk
);

  localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] div_q;
  logic          tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else if (!run) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign pump_clk = tog_q & run;

endmodule

// File: rtl/hb_seq_fsm.sv
`timescale 1ns/1ps
module hb_seq_fsm
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_s,
  input  logic sel_s,
  input  logic sw_low_s,
  input  logic hi_off_s,
  input  logic lo_off_s,
  output logic hi_on,
  output logic lo_on,
  output logic top_req
);

  hb_state_e state_q, state_d;

  // High-side request: any low select clears it; bootstrap evidence sets it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      top_req <= 1'b0;
    else if (!sel_s)
      top_req <= 1'b0;
    else if (sw_low_s)
      top_req <= 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (!run_s) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (top_req && lo_off_s)       state_d = ST_HI_ON;
          else if (!top_req && hi_off_s) state_d = ST_LO_ON;
        end
        ST_LO_ON: begin
          if (top_req) state_d = ST_LO_RELEASE;
        end
        ST_LO_RELEASE: begin
          if (lo_off_s) state_d = top_req ? ST_HI_ON : ST_LO_ON;
        end
        ST_HI_ON: begin
          if (!top_req) state_d = ST_HI_RELEASE;
        end
        ST_HI_RELEASE: begin
          if (hi_off_s) state_d = top_req ? ST_HI_ON : ST_LO_ON;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign hi_on = (state_q == ST_HI_ON);
  assign lo_on = (state_q == ST_LO_ON);

endmodule

// File: rtl/halfbridge_handover.sv
`timescale 1ns/1ps
module halfbridge_handover #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned KICK_NS    = 2000,
  parameter int unsigned PUMP_HZ    = 500_000,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_top,
  input  logic halt,
  input  logic hi_gate_off,
  input  logic lo_gate_off,
  input  logic sw_node_low,
  output logic hi_on,
  output logic lo_on,
  output logic hi_kick,
  output logic lo_kick,
  output logic lo_hold,
  output logic hi_pump
);

  localparam int unsigned KICK_CYC  = hb_pkg::ns_to_cycles(CLK_HZ, KICK_NS);
  localparam int unsigned PUMP_HALF = hb_pkg::half_period(CLK_HZ, PUMP_HZ);
  localparam int unsigned N_IN      = 5;
  localparam int unsigned N_SIDE    = 2;
  // synchronizer lanes: [4] select, [3] halt, [2] hi off, [1] lo off, [0] node low
  localparam logic [N_IN-1:0] SYNC_RST = 5'b01110;

  logic [N_IN-1:0] raw_in, sync_out;
  logic sync_sel, sync_run, sync_hi_off, sync_lo_off, sync_sw_low;
  logic top_req;
  logic [N_SIDE-1:0] side_on, side_kick, side_hold;

  assign raw_in = {sel_top, halt, hi_gate_off, lo_gate_off, sw_node_low};

  hb_sync #(
    .WIDTH  (N_IN),
    .STAGES (SYNC_DEPTH),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (raw_in),
    .dout(sync_out)
  );

  assign sync_sel    = sync_out[4];
  assign sync_run    = ~sync_out[3];
  assign sync_hi_off = sync_out[2];
  assign sync_lo_off = sync_out[1];
  assign sync_sw_low = sync_out[0];

  hb_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_s   (sync_run),
    .sel_s   (sync_sel),
    .sw_low_s(sync_sw_low),
    .hi_off_s(sync_hi_off),
    .lo_off_s(sync_lo_off),
    .hi_on   (hi_on),
    .lo_on   (lo_on),
    .top_req (top_req)
  );

  // side index 1 = high side, 0 = low side
  assign side_on = {hi_on, lo_on};

  for (genvar g = 0; g < N_SIDE; g++) begin : g_side
    hb_oneshot #(.LEN(KICK_CYC)) u_shot (
      .clk  (clk),
      .rst_n(rst_n),
      .on   (side_on[g]),
      .kick (side_kick[g]),
      .hold (side_hold[g])
    );
  end

  hb_pump #(.HALF(PUMP_HALF)) u_pump (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (side_hold[1]),
    .pump_clk(hi_pump)
  );

  assign hi_kick = side_kick[1];
  assign lo_kick = side_kick[0];
  assign lo_hold = side_hold[0];

endmodule

// File: rtl/hb_handover_chk.sv
`timescale 1ns/1ps
module hb_handover_chk (
  input logic clk,
  input logic rst_n,
  input logic hi_on,
  input logic lo_on,
  input logic hi_kick,
  input logic lo_kick,
  input logic hi_pump,
  input logic run_s,
  input logic hi_off_s,
  input logic lo_off_s,
  input logic top_req
);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_on && lo_on));

  assert_hi_waits_lo_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_on) |-> $past(lo_off_s));

  assert_lo_waits_hi_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_on) |-> $past(hi_off_s));

  assert_halt_forces_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_s |=> (!hi_on && !lo_on));

  assert_hi_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_on) |-> $past(top_req));

  assert_kick_on_turn_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_on) || $rose(lo_on)) |-> (hi_kick || lo_kick));

  assert_pump_after_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pump |-> (hi_on && !hi_kick));

endmodule

bind halfbridge_handover hb_handover_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hi_on   (hi_on),
  .lo_on   (lo_on),
  .hi_kick (hi_kick),
  .lo_kick (lo_kick),
  .hi_pump (hi_pump),
  .run_s   (sync_run),
  .hi_off_s(sync_hi_off),
  .lo_off_s(sync_lo_off),
  .top_req (top_req)
);

// File: tb/halfbridge_handover_tb_top.sv
`timescale 1ns/1ps
module halfbridge_handover_tb_top;

  localparam int CLK_PERIOD = 100;            // 10 MHz
  localparam int TB_CLK_HZ  = 10_000_000;
  localparam int EXP_KICK   = 20;             // 2 us at 10 MHz
  localparam int EXP_PUMP   = 20;             // 500 kHz period in cycles
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_top = 1'b0;
  logic halt = 1'b0;
  logic hi_gate_off = 1'b1;
  logic lo_gate_off = 1'b1;
  logic sw_node_low = 1'b0;
  logic hi_on, lo_on, hi_kick, lo_kick, lo_hold, hi_pump;

  logic auto_flags = 1'b1;
  logic man_hi_off = 1'b1, man_lo_off = 1'b1, man_sw_low = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int overlap_cycles = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfbridge_handover #(.CLK_HZ(TB_CLK_HZ)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_top    (sel_top),
    .halt       (halt),
    .hi_gate_off(hi_gate_off),
    .lo_gate_off(lo_gate_off),
    .sw_node_low(sw_node_low),
    .hi_on      (hi_on),
    .lo_on      (lo_on),
    .hi_kick    (hi_kick),
    .lo_kick    (lo_kick),
    .lo_hold    (lo_hold),
    .hi_pump    (hi_pump)
  );

  // Gate model: flags follow the commands one cycle late, or take manual values.
  always @(negedge clk) begin
    if (auto_flags) begin
      hi_gate_off <= !hi_on;
      lo_gate_off <= !lo_on;
      sw_node_low <= !hi_on;
    end else begin
      hi_gate_off <= man_hi_off;
      lo_gate_off <= man_lo_off;
      sw_node_low <= man_sw_low;
    end
    if (rst_n && hi_on && lo_on) overlap_cycles++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog R1..: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Waits for a side to turn on, counts its kick width and notes pump activity.
  task automatic measure_kick(input bit hi_side, output int width, output int pump_seen);
    width = 0;
    pump_seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (hi_side ? hi_on : lo_on) break;
      @(negedge clk);
    end
    for (int i = 0; i < 1000; i++) begin
      if (!(hi_side ? hi_kick : lo_kick)) break;
      width++;
      if (hi_pump) pump_seen = 1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    idle(5);
    chk("R1", "hi_on in reset", hi_on, 0);
    chk("R1", "lo_on in reset", lo_on, 0);
    chk("R1", "drives in reset", {hi_kick, lo_kick, lo_hold, hi_pump}, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "commands after reset", {hi_on, lo_on}, 0);
  endtask

  task automatic t_startup_low_r3_r7();
    int w, p;
    measure_kick(1'b0, w, p);
    chk("R7", "low kick width", w, EXP_KICK);
    chk("R7", "low hold after kick", lo_hold, 1);
    chk("R7", "low kick ended", lo_kick, 0);
    chk("R3", "sel 0 gives low side", {hi_on, lo_on}, 2'b01);
  endtask

  task automatic t_to_high_r10_r8();
    int w, p, n;
    logic prev;
    sel_top = 1'b1;
    idle(2);
    chk("R10", "low still on two edges after change", lo_on, 1);
    measure_kick(1'b1, w, p);
    chk("R7", "high kick width", w, EXP_KICK);
    chk("R8", "pump quiet during kick", p, 0);
    chk("R3", "sel 1 gives high side", {hi_on, lo_on}, 2'b10);
    chk("R7", "low hold dropped", lo_hold, 0);
    prev = hi_pump;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hi_pump && !prev) break;
      prev = hi_pump;
    end
    n = 0;
    prev = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (hi_pump && !prev) break;
      prev = hi_pump;
    end
    chk("R8", "pump period", n, EXP_PUMP);
  endtask

  task automatic t_wait_off_flag_r4();
    man_hi_off = 1'b0; man_lo_off = 1'b1; man_sw_low = 1'b0;
    auto_flags = 1'b0;
    sel_top = 1'b0;
    idle(6);
    chk("R4", "high dropped first", {hi_on, lo_on}, 0);
    idle(20);
    chk("R4", "low held while high flag 0", {hi_on, lo_on}, 0);
    man_hi_off = 1'b1;
    idle(6);
    chk("R4", "low on after high flag", {hi_on, lo_on}, 2'b01);
  endtask

  task automatic t_reversal_r9();
    man_hi_off = 1'b1; man_lo_off = 1'b0; man_sw_low = 1'b1;
    sel_top = 1'b1;
    idle(7);
    chk("R9", "low released, waiting", {hi_on, lo_on}, 0);
    sel_top = 1'b0;
    idle(12);
    chk("R9", "reversed but low flag 0", {hi_on, lo_on}, 0);
    man_lo_off = 1'b1;
    idle(6);
    chk("R9", "low back after its flag", {hi_on, lo_on}, 2'b01);
  endtask

  task automatic t_bootstrap_r6();
    man_hi_off = 1'b1; man_lo_off = 1'b1; man_sw_low = 1'b0;
    sel_top = 1'b1;
    idle(12);
    chk("R6", "no node low, low stays", {hi_on, lo_on}, 2'b01);
    man_sw_low = 1'b1;
    idle(8);
    chk("R6", "node low lets high on", {hi_on, lo_on}, 2'b10);
    man_sw_low = 1'b0;
    idle(8);
    chk("R6", "request held after node rises", {hi_on, lo_on}, 2'b10);
    sel_top = 1'b0;
    idle(8);
    chk("R6", "low select back to low", {hi_on, lo_on}, 2'b01);
    sel_top = 1'b1;
    idle(12);
    chk("R6", "request cleared by low level", {hi_on, lo_on}, 2'b01);
  endtask

  task automatic t_halt_r2();
    auto_flags = 1'b1;
    idle(12);
    chk("R2", "high on before halt", hi_on, 1);
    halt = 1'b1;
    idle(4);
    chk("R2", "halt: commands off", {hi_on, lo_on}, 0);
    chk("R2", "halt: drives off", {hi_kick, lo_kick, lo_hold, hi_pump}, 0);
    sel_top = 1'b0;
    idle(6);
    chk("R2", "halt: sel 0 ignored", {hi_on, lo_on}, 0);
    sel_top = 1'b1;
    idle(6);
    chk("R2", "halt: sel 1 ignored", {hi_on, lo_on}, 0);
    halt = 1'b0;
    idle(8);
    chk("R2", "resume follows sel", {hi_on, lo_on}, 2'b10);
  endtask

  initial begin
    t_reset_r1();
    t_startup_low_r3_r7();
    t_to_high_r10_r8();
    t_wait_off_flag_r4();
    t_reversal_r9();
    t_bootstrap_r6();
    t_halt_r2();
    chk("R5", "cycles with both on", overlap_cycles, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule